// File: doc/BRIEF.md
# Two-Entry Conflict-Free Queue

This block is a small queue that holds at most two words. It is built from a head slot and a tail slot, each with its own valid flag. A writer raises `push_valid` with `push_word`, and a reader takes `head_word` and raises `pop_valid`. Both may act in the same cycle whenever the queue holds exactly one word. A push in a cycle never changes what that cycle's pop sees, and a pop never changes what that cycle's push sees.

A push always lands in the tail slot, and a pop only clears the head slot. At the end of every cycle a settle step runs. If the tail holds a word and the head does not, the step moves the word down into the head. A lone word therefore always sits in the head. Because each slot has only one writer, no slot is written twice in a cycle. The status outputs come straight from the two valid flags and do not depend on the same cycle's requests.

Top module: `twoslot_cf_fifo`

## Requirements
- R1: During and after synchronous reset (`rst` high at a clock edge), the queue is empty: `has_data` is 0 and `has_room` is 1.
- R2: `has_room` is 0 exactly when two words are held. `push_valid` may only be raised while `has_room` is 1.
- R3: `has_data` is 1 exactly when at least one word is held, and `head_word` then shows the oldest word held. `pop_valid` may only be raised while `has_data` is 1.
- R4: A push into an empty queue makes `has_data` 1, with `head_word` equal to the pushed word, from the next cycle on.
- R5: A push and a pop in the same cycle, with one word held, leave one word held. From the next cycle `head_word` shows the pushed word and `has_room` stays 1.
- R6: A pop with two words held leaves one word, and the newer word appears at `head_word` on the next cycle. A single held word is always reported through `head_word`.
- R7: Under any legal sequence of pushes and pops, words leave in the order they entered.
- R8: `has_room` and `has_data` do not change within a cycle when `push_valid` or `pop_valid` change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Push `push_word` this cycle |
| push_word | input | DATA_W | Word to push |
| pop_valid | input | 1 | Remove the head word this cycle |
| has_room | output | 1 | Queue can accept a push |
| has_data | output | 1 | Queue holds at least one word |
| head_word | output | DATA_W | Oldest held word |

## Verification
The bench builds the queue with `DATA_W` set to 4. That brings all sixteen word values within reach of a full sweep: each value is pushed through every occupancy and every legal push/pop pairing. A long stretch of legal random traffic then runs against a two-entry reference model. This traffic includes many cycles with a simultaneous push and pop while one word is held.

// File: rtl/twoslot_pkg.sv
package twoslot_pkg;

    // Occupancy of the two slots.
    typedef struct packed {
        logic head_v;
        logic tail_v;
    } occ_t;

    // Result of one cycle's update: next flags plus whether the tail moves down.
    typedef struct packed {
        occ_t nxt;
        logic move;
    } step_t;

    // Apply push to tail, pop to head, then settle a lone tail word into the head.
    function automatic step_t occ_step(occ_t cur, logic push, logic pop);
        occ_t  mid;
        step_t r;
        mid.tail_v = cur.tail_v | push;
        mid.head_v = cur.head_v & ~pop;
        r.move     = mid.tail_v & ~mid.head_v;
        if (r.move) begin
            r.nxt.head_v = 1'b1;
            r.nxt.tail_v = 1'b0;
        end else begin
            r.nxt = mid;
        end
        return r;
    endfunction

endpackage

// File: rtl/twoslot_slot.sv
module twoslot_slot #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              load,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (load) q <= d;
    end
endmodule

// File: rtl/twoslot_ctrl.sv
module twoslot_ctrl
    import twoslot_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic push_valid,
    input  logic pop_valid,
    output logic head_v,
    output logic tail_v,
    output logic tail_load,
    output logic head_load,
    output logic head_from_input
);
    occ_t  occ_q;
    step_t step;
    logic  push_ok;
    logic  pop_ok;

    assign push_ok = push_valid & ~occ_q.tail_v;
    assign pop_ok  = pop_valid & occ_q.head_v;
    assign step    = occ_step(occ_q, push_ok, pop_ok);

    assign tail_load       = push_ok;
    assign head_load       = step.move;
    assign head_from_input = push_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q.head_v <= 1'b0;
            occ_q.tail_v <= 1'b0;
        end else begin
            occ_q <= step.nxt;
        end
    end

    assign head_v = occ_q.head_v;
    assign tail_v = occ_q.tail_v;

    assert_push_legal_R2: assert property (@(posedge clk) disable iff (rst)
        push_valid |-> !tail_v);

    assert_pop_legal_R3: assert property (@(posedge clk) disable iff (rst)
        pop_valid |-> head_v);

    assert_lone_in_head_R6: assert property (@(posedge clk) disable iff (rst)
        tail_v |-> head_v);

    assert_full_pop_R6: assert property (@(posedge clk) disable iff (rst)
        (head_v && tail_v && pop_valid) |=> (head_v && !tail_v));
endmodule

// File: rtl/twoslot_cf_fifo.sv
module twoslot_cf_fifo #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_word,
    input  logic              pop_valid,
    output logic              has_room,
    output logic              has_data,
    output logic [DATA_W-1:0] head_word
);
    logic              head_v;
    logic              tail_v;
    logic              tail_load;
    logic              head_load;
    logic              head_from_input;
    logic [DATA_W-1:0] tail_q;
    logic [DATA_W-1:0] head_d;

    twoslot_ctrl u_ctrl (
        .clk             (clk),
        .rst             (rst),
        .push_valid      (push_valid),
        .pop_valid       (pop_valid),
        .head_v          (head_v),
        .tail_v          (tail_v),
        .tail_load       (tail_load),
        .head_load       (head_load),
        .head_from_input (head_from_input)
    );

    twoslot_slot #(.DATA_W(DATA_W)) u_tail (
        .clk  (clk),
        .load (tail_load),
        .d    (push_word),
        .q    (tail_q)
    );

    assign head_d = head_from_input ? push_word : tail_q;

    twoslot_slot #(.DATA_W(DATA_W)) u_head (
        .clk  (clk),
        .load (head_load),
        .d    (head_d),
        .q    (head_word)
    );

    assign has_room = ~tail_v;
    assign has_data = head_v;

    assert_empty_fill_R4: assert property (@(posedge clk) disable iff (rst)
        (!has_data && push_valid) |=> (has_data && head_word == $past(push_word)));

    assert_swap_one_R5: assert property (@(posedge clk) disable iff (rst)
        (has_data && has_room && push_valid && pop_valid)
        |=> (has_data && has_room && head_word == $past(push_word)));
endmodule

// File: tb/twoslot_cf_fifo_bench.sv
`timescale 1ns/1ps
module twoslot_cf_fifo_bench;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          push_valid = 1'b0;
    logic [DW-1:0] push_word = '0;
    logic          pop_valid = 1'b0;
    logic          has_room;
    logic          has_data;
    logic [DW-1:0] head_word;

    int            n_checks = 0;
    int            n_fail = 0;
    logic [DW-1:0] m [0:1];
    int            cnt = 0;
    bit            done = 0;

    always #2.5 clk = ~clk;

    twoslot_cf_fifo #(.DATA_W(DW)) u_twoslot_cf_fifo (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_word(push_word),
        .pop_valid(pop_valid), .has_room(has_room), .has_data(has_data),
        .head_word(head_word)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " has_data"}, 32'(has_data), 32'(cnt > 0));
        chk({tag, " has_room"}, 32'(has_room), 32'(cnt < 2));
        if (cnt > 0) chk({tag, " head_word"}, 32'(head_word), 32'(m[0]));
    endtask

    // Called at a negedge: drive this cycle's requests and update the model
    // for the coming rising edge, then check at the following negedge.
    task automatic step(input logic p, input logic q, input logic [DW-1:0] w, input string tag);
        push_valid = p; pop_valid = q; push_word = w;
        if (q && cnt > 0) begin m[0] = m[1]; cnt--; end
        if (p && cnt < 2) begin m[cnt] = w; cnt++; end
        @(negedge clk);
        push_valid = 0; pop_valid = 0;
        check_all(tag);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic r0, r1, hr, hd;
        repeat (3) @(negedge clk);
        check_all("R1 in reset");
        rst = 0;
        @(negedge clk);
        check_all("R1 after reset");

        step(1, 0, 4'h9, "R4 fill empty");
        step(1, 0, 4'h3, "R2 now full");
        step(0, 1, 4'h0, "R6 pop from full");
        step(1, 1, 4'hc, "R5 push+pop one held");
        step(0, 1, 4'h0, "R3 drain");

        // R8: flags stay put within the cycle while requests toggle.
        step(1, 0, 4'h5, "R8 setup");
        hr = has_room; hd = has_data;
        push_valid = 1; pop_valid = 1;
        #1;
        r0 = has_room; r1 = has_data;
        push_valid = 0; pop_valid = 0;
        chk("R8 has_room", 32'(r0), 32'(hr));
        chk("R8 has_data", 32'(r1), 32'(hd));
        step(0, 1, 4'h0, "R8 cleanup");

        // Sweep every word value through every legal pairing at each occupancy.
        for (int v = 0; v < 16; v++) begin
            step(1, 0, DW'(v), "R4 sweep");
            step(1, 1, DW'(v + 1), "R5 sweep");
            step(1, 0, DW'(v + 2), "R2 sweep");
            step(0, 1, 4'h0, "R6 sweep");
            step(0, 1, 4'h0, "R3 sweep");
        end

        // Legal random traffic against the model.
        for (int i = 0; i < 4000; i++) begin
            logic p, q;
            p = 1'($urandom) && cnt < 2;
            q = 1'($urandom) && cnt > 0;
            step(p, q, DW'($urandom), "R7 order");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule